// File: doc/BRIEF.md
# Serial Receive FIFO with Grouped DMA Requests

This block sits on the receive side of a serial port. Each byte from the deserializer lands in an eight-entry byte FIFO. A three-bit service setting chooses how each direction is serviced. The choices are status polling, an interrupt while status is set, or DMA. DMA may be selected for at most one direction at a time.

When receive is in DMA mode, the block counts accepted writes. It raises an active-low, level-signalled read request once a group of four bytes has gathered. That happens each time the write pointer steps onto entry 4 and each time it wraps onto entry 0. An external DMA engine answers each beat with an acknowledge, and each acknowledge pops one byte. The request stays low until four beats have drained the group.

Outside receive DMA mode, the CPU reads the FIFO through a read strobe. A write into a full FIFO is lost and sets a sticky overrun flag.

Top module: `srx_dma_requester`

## Requirements
- R1: After a synchronous active-high reset, the following hold: the FIFO is empty (`rx_avail`=0), both DMA requests are high, both interrupts are low, and `ovr_flag` and `cfg_err` are 0.
- R2: Bytes leave the FIFO in arrival order, and the FIFO holds up to 8 bytes. `rd_data` always shows the oldest stored byte, and `rx_avail` is 1 whenever at least one byte is stored.
- R3: A byte offered while 8 bytes are stored is discarded, and `ovr_flag` is set. The flag remains set until a cycle with `ovr_clr`=1 and no new overrun; a fresh overrun wins over the clear.
- R4: The mode bits are `{cfg_dma_en, cfg_tx_ie, cfg_rx_ie}`. In receive DMA mode (bits 101), every accepted write that moves the write pointer onto entry 4 or onto entry 0 adds one pending 4-byte group. `rx_dreq_n` is 0 while any group is pending.
- R5: In receive DMA mode, each cycle with `rx_dreq_n`=0 and `dma_ack`=1 pops one byte. After the fourth such pop of a group, that group is retired, and the request rises when no group remains.
- R6: With `cfg_dma_en`=0, each direction uses its own enable bit: 0 selects polling, 1 selects interrupt. In interrupt mode, `rx_irq` equals `rx_avail` and `tx_irq` equals `tx_ready`. In polling mode, the interrupt stays 0.
- R7: Setting 101 gives receive read DMA and transmit interrupt. Setting 110 gives transmit write DMA (`tx_dreq_n` = NOT `tx_ready`) and receive interrupt. The two DMA requests are never low together.
- R8: Settings 100 and 111 are prohibited. Under either, `cfg_err`=1, both requests stay high, both interrupts stay 0, and the CPU may read. Groups already pending are kept and request again once 101 is restored.
- R9: `dma_ack` has no effect while `rx_dreq_n` is high: no byte is popped.
- R10: `rd_en` pops a byte only when receive is not in DMA mode and the FIFO is not empty. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_en | input | 1 | Service setting: DMA enable |
| cfg_tx_ie | input | 1 | Service setting: transmit enable |
| cfg_rx_ie | input | 1 | Service setting: receive enable |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rd_en | input | 1 | CPU read strobe |
| rd_data | output | 8 | Oldest stored byte |
| rx_avail | output | 1 | FIFO not empty |
| dma_ack | input | 1 | DMA engine accepts one beat |
| rx_dreq_n | output | 1 | Receive read DMA request, active low |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_dreq_n | output | 1 | Transmit write DMA request, active low |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun |
| cfg_err | output | 1 | Prohibited service setting |

## Verification
Every output comes from registers and from the current inputs through logic only, with no extra pipeline stage. A write, a pop, an overrun or a group change made at a rising edge is due on the outputs just after that edge. A change to the service setting is due in the same cycle. The bench drives each cycle's inputs at the falling edge. It compares the outputs 1 ns later against a model that has absorbed every earlier edge. The model advances only after the next rising edge, so each comparison falls in the cycle where the result is due.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        SVC_POLL = 2'd0,
        SVC_IRQ  = 2'd1,
        SVC_DMA  = 2'd2
    } svc_e;

    typedef struct packed {
        logic dma_en;
        logic tx_ie;
        logic rx_ie;
    } mode_bits_t;

    typedef struct packed {
        svc_e tx;
        svc_e rx;
        logic bad;
    } svc_cfg_t;

    // Prohibited settings fall back to polling on both sides.
    function automatic svc_cfg_t decode_mode(input mode_bits_t m);
        svc_cfg_t s;
        s.bad = 1'b0;
        s.tx  = SVC_POLL;
        s.rx  = SVC_POLL;
        if (!m.dma_en) begin
            s.tx = m.tx_ie ? SVC_IRQ : SVC_POLL;
            s.rx = m.rx_ie ? SVC_IRQ : SVC_POLL;
        end else if (m.rx_ie && !m.tx_ie) begin
            s.rx = SVC_DMA;
            s.tx = SVC_IRQ;
        end else if (m.tx_ie && !m.rx_ie) begin
            s.tx = SVC_DMA;
            s.rx = SVC_IRQ;
        end else begin
            s.bad = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/srx_mode_dec.sv
module srx_mode_dec
    import srx_pkg::*;
(
    input  mode_bits_t mode,
    output svc_cfg_t   svc
);
    always_comb svc = decode_mode(mode);

    always_comb begin
        if (svc.tx == SVC_DMA && svc.rx == SVC_DMA)
            p_single_dma_r7: assert (1'b0) else $error("both directions decoded to DMA");
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int GROUP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         drop,
    output logic         grp_edge
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = AW + 1;
    localparam int GAW = $clog2(GROUP);
    localparam logic [GAW-1:0] LAST = GAW'(GROUP - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign push_ok  = wr && !full;
    assign pop_ok   = pop && !empty;
    assign drop     = wr && full;
    assign grp_edge = push_ok && (wptr[GAW-1:0] == LAST);
    assign dout     = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !pop) |=> full);
endmodule

// File: rtl/srx_req_ctl.sv
module srx_req_ctl #(
    parameter int DEPTH = 8,
    parameter int GROUP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic grp_edge,
    input  logic allow,
    input  logic ack,
    input  logic empty,
    output logic req,
    output logic dma_pop
);
    localparam int GAW = $clog2(GROUP);
    localparam int GCW = $clog2(DEPTH / GROUP + 1);
    localparam logic [GAW-1:0] LAST = GAW'(GROUP - 1);

    logic [GCW-1:0] grp;
    logic [GAW-1:0] beat;
    logic           grp_inc, grp_dec;

    assign req     = allow && (grp != '0);
    assign dma_pop = req && ack && !empty;
    assign grp_inc = allow && grp_edge;
    assign grp_dec = dma_pop && (beat == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            grp  <= '0;
            beat <= '0;
        end else begin
            if (dma_pop) beat <= (beat == LAST) ? '0 : beat + 1'b1;
            case ({grp_inc, grp_dec})
                2'b10:   grp <= grp + 1'b1;
                2'b01:   grp <= grp - 1'b1;
                default: grp <= grp;
            endcase
        end
    end

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req && !ack && allow) |=> (req || !allow));
    p_idle_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (!req && !grp_inc) |=> $stable(beat));
endmodule

// File: rtl/srx_dma_requester.sv
module srx_dma_requester
    import srx_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int GROUP = DEPTH / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_dma_en,
    input  logic         cfg_tx_ie,
    input  logic         cfg_rx_ie,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_byte,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rx_avail,
    input  logic         dma_ack,
    output logic         rx_dreq_n,
    input  logic         tx_ready,
    output logic         tx_dreq_n,
    output logic         rx_irq,
    output logic         tx_irq,
    input  logic         ovr_clr,
    output logic         ovr_flag,
    output logic         cfg_err
);
    mode_bits_t mode;
    svc_cfg_t   svc;
    logic       empty, full, drop, grp_edge;
    logic       rx_dma, req, dma_pop, cpu_pop;

    assign mode = '{dma_en: cfg_dma_en, tx_ie: cfg_tx_ie, rx_ie: cfg_rx_ie};

    srx_mode_dec u_dec (.mode(mode), .svc(svc));

    assign rx_dma  = (svc.rx == SVC_DMA);
    assign cpu_pop = rd_en && !rx_dma && !empty;

    srx_fifo #(.W(W), .DEPTH(DEPTH), .GROUP(GROUP)) u_fifo (
        .clk(clk), .rst(rst), .wr(rx_valid), .din(rx_byte),
        .pop(cpu_pop || dma_pop), .dout(rd_data), .empty(empty),
        .full(full), .drop(drop), .grp_edge(grp_edge)
    );

    srx_req_ctl #(.DEPTH(DEPTH), .GROUP(GROUP)) u_req (
        .clk(clk), .rst(rst), .grp_edge(grp_edge), .allow(rx_dma),
        .ack(dma_ack), .empty(empty), .req(req), .dma_pop(dma_pop)
    );

    always_ff @(posedge clk) begin
        if (rst)          ovr_flag <= 1'b0;
        else if (drop)    ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    assign rx_avail  = !empty;
    assign rx_dreq_n = !req;
    assign tx_dreq_n = !((svc.tx == SVC_DMA) && tx_ready);
    assign rx_irq    = (svc.rx == SVC_IRQ) && !empty;
    assign tx_irq    = (svc.tx == SVC_IRQ) && tx_ready;
    assign cfg_err   = svc.bad;

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (rx_dreq_n && tx_dreq_n && !rx_irq && !tx_irq));
    p_one_dir_r7: assert property (@(posedge clk) disable iff (rst)
        $countones({!rx_dreq_n, !tx_dreq_n}) <= 1);
    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag);
    p_irq_data_r6: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rx_avail);
endmodule

// File: tb/sim_srx_dma_requester.sv
`timescale 1ns/1ps
module sim_srx_dma_requester;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] cfg = 3'b000;
    logic rx_valid = 0, rd_en = 0, dma_ack = 0, tx_ready = 0, ovr_clr = 0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rd_data;
    logic rx_avail, rx_dreq_n, tx_dreq_n, rx_irq, tx_irq, ovr_flag, cfg_err;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    byte unsigned q[$];
    int  m_grp = 0, m_beat = 0, m_wp = 0;
    bit  m_ovr = 0;

    always #2 clk = ~clk;

    srx_dma_requester u0 (
        .clk(clk), .rst(rst), .cfg_dma_en(cfg[2]), .cfg_tx_ie(cfg[1]),
        .cfg_rx_ie(cfg[0]), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_en(rd_en), .rd_data(rd_data), .rx_avail(rx_avail),
        .dma_ack(dma_ack), .rx_dreq_n(rx_dreq_n), .tx_ready(tx_ready),
        .tx_dreq_n(tx_dreq_n), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .cfg_err(cfg_err)
    );

    // Service per direction: 0 poll, 1 interrupt, 2 DMA; bad settings give poll.
    function automatic int svc_rx(input logic [2:0] c);
        if (!c[2]) return c[0] ? 1 : 0;
        if (c[1:0] == 2'b01) return 2;
        if (c[1:0] == 2'b10) return 1;
        return 0;
    endfunction
    function automatic int svc_tx(input logic [2:0] c);
        if (!c[2]) return c[1] ? 1 : 0;
        if (c[1:0] == 2'b01) return 1;
        if (c[1:0] == 2'b10) return 2;
        return 0;
    endfunction
    function automatic bit is_bad(input logic [2:0] c);
        return c[2] && (c[1] == c[0]);
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit rx_dma = (svc_rx(cfg) == 2);
        bit req = rx_dma && (m_grp != 0);
        chk("R2 rx_avail", {7'd0, rx_avail}, {7'd0, q.size() != 0});
        if (q.size() != 0) chk("R2 rd_data", rd_data, q[0]);
        chk("R4/R5 rx_dreq_n", {7'd0, rx_dreq_n}, {7'd0, !req});
        chk("R7 tx_dreq_n", {7'd0, tx_dreq_n}, {7'd0, !(svc_tx(cfg) == 2 && tx_ready)});
        chk("R6 rx_irq", {7'd0, rx_irq}, {7'd0, svc_rx(cfg) == 1 && q.size() != 0});
        chk("R6 tx_irq", {7'd0, tx_irq}, {7'd0, svc_tx(cfg) == 1 && tx_ready});
        chk("R8 cfg_err", {7'd0, cfg_err}, {7'd0, is_bad(cfg)});
        chk("R3 ovr_flag", {7'd0, ovr_flag}, {7'd0, m_ovr});
    endtask

    task automatic advance();
        bit rx_dma = (svc_rx(cfg) == 2);
        bit req = rx_dma && (m_grp != 0);
        bit full = (q.size() == 8);
        bit dpop = req && dma_ack && q.size() != 0;   // R5, R9
        bit cpop = rd_en && !rx_dma && q.size() != 0; // R10
        bit drop = rx_valid && full;
        if (rx_valid && !full) begin
            q.push_back(rx_byte);
            if (rx_dma && (m_wp % 4) == 3) m_grp++;
            m_wp = (m_wp + 1) % 8;
        end
        if (dpop || cpop) void'(q.pop_front());
        if (dpop) begin
            if (m_beat == 3) begin m_beat = 0; m_grp--; end
            else m_beat++;
        end
        if (drop) m_ovr = 1;
        else if (ovr_clr) m_ovr = 0;
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit rd,
                        input bit ack, input bit clr, input bit txr);
        rx_valid = v; rx_byte = b; rd_en = rd; dma_ack = ack;
        ovr_clr = clr; tx_ready = txr;
        #1 compare();
        @(posedge clk);
        advance();
        @(negedge clk);
    endtask

    task automatic rnd_cycles(input int n, input int pv, input int prd, input int pack);
        for (int i = 0; i < n; i++)
            step(($urandom % 100) < pv, 8'($urandom), ($urandom % 100) < prd,
                 ($urandom % 100) < pack, ($urandom % 16) == 0, $urandom % 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 rx_avail", {7'd0, rx_avail}, 8'd0);
        chk("R1 rx_dreq_n", {7'd0, rx_dreq_n}, 8'd1);
        chk("R1 tx_dreq_n", {7'd0, tx_dreq_n}, 8'd1);
        chk("R1 irq", {6'd0, rx_irq, tx_irq}, 8'd0);
        chk("R1 flags", {6'd0, ovr_flag, cfg_err}, 8'd0);

        // R2/R3: polling, fill past full, clear, drain in order
        cfg = 3'b000;
        for (int i = 0; i < 10; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 9; i++) step(0, 0, 1, 0, i == 4, 0);
        step(0, 0, 1, 0, 0, 0);

        // R6: interrupt mode both sides
        cfg = 3'b011; rnd_cycles(150, 40, 30, 0);
        cfg = 3'b001; rnd_cycles(60, 40, 30, 0);
        // drain before DMA so the pointer phase is arbitrary but known to the model
        cfg = 3'b000; for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 1, 0);

        // R4/R5/R9/R10: receive DMA, acks only after a full group, then random
        cfg = 3'b101;
        for (int i = 0; i < 8; i++) step(1, 8'(8'h10 + i), 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0);
        rnd_cycles(300, 50, 30, 50);

        // R8: prohibited settings hold requests, then pending groups resume
        for (int i = 0; i < 6; i++) step(1, 8'(8'h55 + i), 0, 0, 1, 0);
        cfg = 3'b100; rnd_cycles(20, 0, 0, 60);
        cfg = 3'b111; rnd_cycles(20, 0, 0, 60);
        cfg = 3'b101; rnd_cycles(60, 30, 20, 60);

        // R7: transmit DMA
        cfg = 3'b110; rnd_cycles(100, 40, 30, 50);

        // random mix of all settings
        for (int k = 0; k < 40; k++) begin
            cfg = 3'($urandom);
            rnd_cycles(25, 50, 40, 50);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule